// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a word-addressed register file that owns a parameterised number of general-purpose pins (a multiple of 32). Software reaches every per-pin feature through a bank of consecutive 32-bit words, one bit per pin, and the banks follow one another in a fixed order. The alternate-function selector is the exception: it packs two bits per pin, so its bank is twice as long.

The output latch has no plain write path. It moves only through a write-one-to-set bank and a write-one-to-clear bank, so one pin can be changed without a read-modify-write. Pin inputs pass through a two-flop synchroniser before they can be read back. The rising and falling enable words and the edge-status word are handed to a separate edge-detect block: the enables go out as levels, status comes in as flags, and ones written to status leave as a one-cycle acknowledge pulse.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Reset clears every direction bit, every output latch bit, every enable bit and every function field. As a result `pin_oe`, `pin_out`, `func_sel`, `rise_en`, `fall_en` and `edge_ack` are all zero.
- R2: With W = NUM_PINS/32, the word for bank k and pin p is k*W + p/32, at bit p mod 32. The bank order is: level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge-status 6, function 7.
- R3: A read of the level bank returns `pin_in` after the two-flop synchroniser. A read issued on the clock that follows an input change still returns the old value, and the next read returns the new one.
- R4: A direction bit of 1 makes the pin an output and 0 makes it an input. `pin_oe` follows the direction bit while the pin's function field is 0, and the direction word reads back as written.
- R5: Writing ones to a set-bank word drives those latch bits high. Zero bits leave their latch bits alone, and `pin_out` shows the latch one cycle after the write.
- R6: Writing ones to a clear-bank word drives those latch bits low, and zero bits leave their latch bits alone.
- R7: A read of either the set bank or the clear bank returns the current output latch word.
- R8: The function field is 2 bits wide, in word 7*W + p/16 at bits (p mod 16)*2 and (p mod 16)*2+1. It appears on `func_sel[2p+1:2p]`. While the field is nonzero, `pin_oe` for that pin is 0 whatever the direction bit holds.
- R9: The rising-enable and falling-enable words hold what is written and read it back, and they drive `rise_en` and `fall_en`.
- R10: A read of the edge-status bank returns `edge_flags`. Writing a status word drives the written bits on the matching slice of `edge_ack` for exactly the one cycle after the write, and `edge_ack` is 0 at all other times.
- R11: Writes to the level bank change nothing. An address at or above 9*W reads as 0, and a write to such an address changes nothing.
- R12: `bus_rvalid` is high, with `bus_rdata` valid, for exactly the cycle after a read request. It is low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable, gated by function select |
| func_sel | output | 2*NUM_PINS | Function field per pin, 2 bits each |
| rise_en | output | NUM_PINS | Rising-edge enables to the edge block |
| fall_en | output | NUM_PINS | Falling-edge enables to the edge block |
| edge_flags | input | NUM_PINS | Edge status from the edge block |
| edge_ack | output | NUM_PINS | One-cycle acknowledge of written status bits |

## Verification
The hardest situations to reach are the ones where two controls act on the same pin. One is a pin whose direction bit says output while its function field is nonzero. The other is a pin in the upper word of a bank, where the word index and the bit position of the packed function field both come into play. The stimulus programs pin 63 as an output and then writes its function field in the last word of the function bank. It checks that `pin_oe` drops, and that it comes back once the field is cleared. The synchroniser latency is pinned down by changing `pin_in` on one cycle and reading the level bank on the next, when the old value must still come back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned FN_W       = 2;
   localparam int unsigned FN_PER_WRD = WORD_W / FN_W;

   // Bank ordering is part of the address map and must stay fixed.
   localparam int unsigned BK_LEVEL = 0;
   localparam int unsigned BK_DIR   = 1;
   localparam int unsigned BK_SET   = 2;
   localparam int unsigned BK_CLR   = 3;
   localparam int unsigned BK_RISE  = 4;
   localparam int unsigned BK_FALL  = 5;
   localparam int unsigned BK_STAT  = 6;
   localparam int unsigned BK_FN    = 7;

   localparam int unsigned NBIT_BANKS = 7;

   function automatic int unsigned words_per_bank(int unsigned pins);
      return pins / WORD_W;
   endfunction

   function automatic int unsigned word_addr(int unsigned bank, int unsigned nw, int unsigned idx);
      return bank * nw + idx;
   endfunction

   // Function bank spans twice as many words as a 1-bit bank.
   function automatic int unsigned map_words(int unsigned pins);
      return BK_FN * words_per_bank(pins) + FN_W * words_per_bank(pins);
   endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 64,
   parameter int unsigned ADDR_W   = 6,
   localparam int unsigned NW      = NUM_PINS / WORD_W,
   localparam int unsigned NFW     = FN_W * NW
) (
   input  logic [ADDR_W-1:0]                 addr,
   output logic [NBIT_BANKS-1:0][NW-1:0]     hit_bit,
   output logic [NFW-1:0]                    hit_fn
);
   for (genvar b = 0; b < NBIT_BANKS; b++) begin : g_bank
      for (genvar w = 0; w < NW; w++) begin : g_word
         localparam int unsigned A = word_addr(b, NW, w);
         assign hit_bit[b][w] = (addr == ADDR_W'(A));
      end
   end

   for (genvar f = 0; f < NFW; f++) begin : g_fn
      localparam int unsigned A = word_addr(BK_FN, NW, f);
      assign hit_fn[f] = (addr == ADDR_W'(A));
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 64,
   localparam int unsigned NW      = NUM_PINS / WORD_W,
   localparam int unsigned NFW     = FN_W * NW
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NBIT_BANKS-1:0][NW-1:0] we_bit,
   input  logic [NFW-1:0]                we_fn,
   input  logic [WORD_W-1:0]             wdata,
   output logic [NUM_PINS-1:0]           dir_q,
   output logic [NUM_PINS-1:0]           latch_q,
   output logic [NUM_PINS-1:0]           rise_q,
   output logic [NUM_PINS-1:0]           fall_q,
   output logic [NUM_PINS-1:0]           ack_q,
   output logic [FN_W*NUM_PINS-1:0]      fsel_q,
   output logic [NUM_PINS-1:0]           oe
);
   for (genvar w = 0; w < NW; w++) begin : g_word
      logic [WORD_W-1:0] dir_r, out_r, rise_r, fall_r, ack_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_r  <= '0;
            out_r  <= '0;
            rise_r <= '0;
            fall_r <= '0;
            ack_r  <= '0;
         end else begin
            if (we_bit[BK_DIR][w])  dir_r  <= wdata;
            if (we_bit[BK_RISE][w]) rise_r <= wdata;
            if (we_bit[BK_FALL][w]) fall_r <= wdata;
            if (we_bit[BK_SET][w]) begin
               out_r <= out_r | wdata;
            end else if (we_bit[BK_CLR][w]) begin
               out_r <= out_r & ~wdata;
            end
            ack_r <= we_bit[BK_STAT][w] ? wdata : '0;
         end
      end

      assign dir_q  [w*WORD_W +: WORD_W] = dir_r;
      assign latch_q[w*WORD_W +: WORD_W] = out_r;
      assign rise_q [w*WORD_W +: WORD_W] = rise_r;
      assign fall_q [w*WORD_W +: WORD_W] = fall_r;
      assign ack_q  [w*WORD_W +: WORD_W] = ack_r;
   end

   for (genvar f = 0; f < NFW; f++) begin : g_fn_word
      logic [WORD_W-1:0] fn_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fn_r <= '0;
         end else if (we_fn[f]) begin
            fn_r <= wdata;
         end
      end

      assign fsel_q[f*WORD_W +: WORD_W] = fn_r;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign oe[p] = dir_q[p] & (fsel_q[p*FN_W +: FN_W] == '0);
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 64,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_valid,
   input  logic                     bus_write,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic                     bus_rvalid,
   input  logic [NUM_PINS-1:0]      pin_in,
   output logic [NUM_PINS-1:0]      pin_out,
   output logic [NUM_PINS-1:0]      pin_oe,
   output logic [2*NUM_PINS-1:0]    func_sel,
   output logic [NUM_PINS-1:0]      rise_en,
   output logic [NUM_PINS-1:0]      fall_en,
   input  logic [NUM_PINS-1:0]      edge_flags,
   output logic [NUM_PINS-1:0]      edge_ack
);
   localparam int unsigned NW    = words_per_bank(NUM_PINS);
   localparam int unsigned NFW   = FN_W * NW;
   localparam int unsigned WORDS = map_words(NUM_PINS);

   if (NUM_PINS == 0 || (NUM_PINS % WORD_W) != 0) begin : g_bad_pins
      $error("gpio_bank_ctrl: NUM_PINS must be a nonzero multiple of 32");
   end
   if (WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_bank_ctrl: ADDR_W too narrow for the bank map");
   end

   logic [NUM_PINS-1:0]           lvl_q;
   logic [NBIT_BANKS-1:0][NW-1:0] hit_bit;
   logic [NFW-1:0]                hit_fn;
   logic [NBIT_BANKS-1:0][NW-1:0] we_bit;
   logic [NFW-1:0]                we_fn;
   logic [NUM_PINS-1:0]           dir_q;
   logic                          wr_go;
   logic                          rd_go;

   assign wr_go = bus_valid &  bus_write;
   assign rd_go = bus_valid & ~bus_write;

   gpio_bank_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_q)
   );

   gpio_bank_decode #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W)
   ) u_dec (
      .addr    (bus_addr),
      .hit_bit (hit_bit),
      .hit_fn  (hit_fn)
   );

   // Level bank is read-only: its write strobes are never raised.
   for (genvar b = 0; b < NBIT_BANKS; b++) begin : g_we
      if (b == BK_LEVEL) begin : g_ro
         assign we_bit[b] = '0;
      end else begin : g_rw
         assign we_bit[b] = hit_bit[b] & {NW{wr_go}};
      end
   end
   assign we_fn = hit_fn & {NFW{wr_go}};

   gpio_bank_regs #(
      .NUM_PINS (NUM_PINS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_bit  (we_bit),
      .we_fn   (we_fn),
      .wdata   (bus_wdata),
      .dir_q   (dir_q),
      .latch_q (pin_out),
      .rise_q  (rise_en),
      .fall_q  (fall_en),
      .ack_q   (edge_ack),
      .fsel_q  (func_sel),
      .oe      (pin_oe)
   );

   // Read sources per 1-bit bank; set and clear both return the latch.
   logic [NBIT_BANKS-1:0][NUM_PINS-1:0] bank_vec;
   assign bank_vec[BK_LEVEL] = lvl_q;
   assign bank_vec[BK_DIR]   = dir_q;
   assign bank_vec[BK_SET]   = pin_out;
   assign bank_vec[BK_CLR]   = pin_out;
   assign bank_vec[BK_RISE]  = rise_en;
   assign bank_vec[BK_FALL]  = fall_en;
   assign bank_vec[BK_STAT]  = edge_flags;

   logic [WORD_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NBIT_BANKS; b++) begin
         for (int w = 0; w < NW; w++) begin
            if (hit_bit[b][w]) rd_mux = rd_mux | bank_vec[b][w*WORD_W +: WORD_W];
         end
      end
      for (int f = 0; f < NFW; f++) begin
         if (hit_fn[f]) rd_mux = rd_mux | func_sel[f*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_go;
         if (rd_go) bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int unsigned NUM_PINS = 64,
   parameter int unsigned ADDR_W   = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_valid,
   input logic                     bus_write,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [31:0]              bus_wdata,
   input logic [31:0]              bus_rdata,
   input logic                     bus_rvalid,
   input logic [NUM_PINS-1:0]      pin_out,
   input logic [2*NUM_PINS-1:0]    func_sel,
   input logic [NUM_PINS-1:0]      rise_en,
   input logic [NUM_PINS-1:0]      fall_en,
   input logic [NUM_PINS-1:0]      edge_ack
);
   localparam int unsigned NW   = NUM_PINS / 32;
   localparam int unsigned SET0 = 2 * NW;
   localparam int unsigned CLR0 = 3 * NW;
   localparam int unsigned LAST = 9 * NW;

   logic is_rd, is_wr;
   assign is_rd = bus_valid & ~bus_write;
   assign is_wr = bus_valid &  bus_write;

   p_rvalid_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> bus_rvalid);

   p_rvalid_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !bus_rvalid);

   p_oor_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && 32'(bus_addr) >= LAST) |=> (bus_rdata == '0));

   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wr |=> $stable(pin_out));

   p_set_word0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && 32'(bus_addr) == SET0) |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

   p_clr_word0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && 32'(bus_addr) == CLR0) |=> ((pin_out[31:0] & $past(bus_wdata)) == '0));

   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wr |=> ($stable(rise_en) && $stable(fall_en) && $stable(func_sel)));

   p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_wr |=> (edge_ack == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .pin_out    (pin_out),
   .func_sel   (func_sel),
   .rise_en    (rise_en),
   .fall_en    (fall_en),
   .edge_ack   (edge_ack)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
   localparam int unsigned NP = 64;
   localparam int unsigned AW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_valid = 1'b0;
   logic            bus_write = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            bus_rvalid;
   logic [NP-1:0]   pin_in = '0;
   logic [NP-1:0]   pin_out;
   logic [NP-1:0]   pin_oe;
   logic [2*NP-1:0] func_sel;
   logic [NP-1:0]   rise_en;
   logic [NP-1:0]   fall_en;
   logic [NP-1:0]   edge_flags = '0;
   logic [NP-1:0]   edge_ack;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .func_sel(func_sel), .rise_en(rise_en), .fall_en(fall_en),
      .edge_flags(edge_flags), .edge_ack(edge_ack)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int unsigned a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input int unsigned a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   // {write, addr, data, expected read}; W=2, map: level 0-1, dir 2-3,
   // set 4-5, clr 6-7, rise 8-9, fall 10-11, status 12-13, function 14-17.
   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'd2,  32'h0000_00FF, 32'h0},           // R4 direction word 0
      '{1'b0, 8'd2,  32'h0,         32'h0000_00FF},   // R4 R2 readback
      '{1'b1, 8'd4,  32'h0000_0F0F, 32'h0},           // R5 set
      '{1'b0, 8'd4,  32'h0,         32'h0000_0F0F},   // R7 set bank reads latch
      '{1'b1, 8'd4,  32'h0,         32'h0},           // R5 zeros ignored
      '{1'b0, 8'd6,  32'h0,         32'h0000_0F0F},   // R7 clear bank reads latch
      '{1'b1, 8'd6,  32'h0000_0101, 32'h0},           // R6 clear
      '{1'b0, 8'd4,  32'h0,         32'h0000_0E0E},   // R6 result
      '{1'b1, 8'd5,  32'h8000_0000, 32'h0},           // R2 upper word
      '{1'b0, 8'd5,  32'h0,         32'h8000_0000},   // R2 readback
      '{1'b1, 8'd8,  32'h1234_5678, 32'h0},           // R9 rising word 0
      '{1'b0, 8'd8,  32'h0,         32'h1234_5678},   // R9
      '{1'b1, 8'd11, 32'hCAFE_0001, 32'h0},           // R9 falling word 1
      '{1'b0, 8'd11, 32'h0,         32'hCAFE_0001},   // R9
      '{1'b1, 8'd14, 32'h0000_000C, 32'h0},           // R8 pin 1 field = 3
      '{1'b0, 8'd14, 32'h0,         32'h0000_000C},   // R8
      '{1'b1, 8'd0,  32'hFFFF_FFFF, 32'h0},           // R11 level write
      '{1'b0, 8'd0,  32'h0,         32'h0},           // R11 level unchanged
      '{1'b1, 8'd40, 32'hFFFF_FFFF, 32'h0},           // R11 out of range write
      '{1'b0, 8'd40, 32'h0,         32'h0}            // R11 out of range read
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", 128'(pin_oe), 128'h0);
      check("R1 pin_out", 128'(pin_out), 128'h0);
      check("R1 func_sel", 128'(func_sel), 128'h0);
      check("R1 enables", 128'({rise_en, fall_en}), 128'h0);
      check("R1 edge_ack", 128'(edge_ack), 128'h0);
      rst_n = 1'b1;
      bus_rd(2, rd);
      check("R1 dir read", 128'(rd), 128'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) begin
            bus_wr(int'(VEC[i].addr), VEC[i].data);
         end else begin
            bus_rd(int'(VEC[i].addr), rd);
            check($sformatf("table vector %0d", i), 128'(rd), 128'(VEC[i].exp));
         end
      end

      // Port state after the table
      check("R11 dir untouched", 128'(pin_oe[31:0] | 32'h2), 128'h0000_00FF);
      check("R8 pin1 oe gated", 128'(pin_oe), 128'h0000_0000_0000_00FD);
      check("R5 pin_out", 128'(pin_out), 128'h8000_0000_0000_0E0E);
      check("R8 func_sel", 128'(func_sel), 128'hC);
      check("R9 rise_en", 128'(rise_en), 128'h0000_0000_1234_5678);
      check("R9 fall_en", 128'(fall_en), 128'hCAFE_0001_0000_0000);

      // R12 valid timing
      bus_rd(3, rd);
      check("R12 rvalid after read", 128'(bus_rvalid), 128'h1);
      @(negedge clk);
      check("R12 rvalid idle", 128'(bus_rvalid), 128'h0);

      // R8 pin 63: dir word 1 bit 31, function word 17 bits 31:30
      bus_wr(3, 32'h8000_0000);
      check("R4 pin63 oe", 128'(pin_oe[63]), 128'h1);
      bus_wr(17, 32'h4000_0000);
      check("R8 pin63 func_sel", 128'(func_sel[127:126]), 128'h1);
      check("R8 pin63 oe gated", 128'(pin_oe[63]), 128'h0);
      bus_rd(17, rd);
      check("R8 word 17 read", 128'(rd), 128'h4000_0000);
      bus_wr(17, 32'h0);
      check("R8 pin63 oe restored", 128'(pin_oe[63]), 128'h1);

      // R3 synchroniser latency
      @(negedge clk);
      pin_in = 64'h0123_4567_89AB_CDEF;
      bus_rd(0, rd);
      check("R3 old level", 128'(rd), 128'h0);
      bus_rd(0, rd);
      check("R3 level word 0", 128'(rd), 128'h89AB_CDEF);
      bus_rd(1, rd);
      check("R3 level word 1", 128'(rd), 128'h0123_4567);

      // R10 status read and ack pulse
      edge_flags = 64'h0000_0005_A000_0000;
      bus_rd(12, rd);
      check("R10 status word 0", 128'(rd), 128'hA000_0000);
      bus_rd(13, rd);
      check("R10 status word 1", 128'(rd), 128'h5);
      bus_wr(13, 32'h3);
      check("R10 ack pulse", 128'(edge_ack), 128'h0000_0003_0000_0000);
      @(negedge clk);
      check("R10 ack cleared", 128'(edge_ack), 128'h0);

      // R1 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 oe after reset", 128'(pin_oe), 128'h0);
      check("R1 out after reset", 128'(pin_out), 128'h0);
      check("R1 cfg after reset", 128'({rise_en, fall_en, func_sel}), 128'h0);
      rst_n = 1'b1;
      bus_rd(4, rd);
      check("R7 latch read after reset", 128'(rd), 128'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule